// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address for 4 KiB pages. It does this by reading two entries from memory. A request carries the virtual address and the current value of the table-base register. The walker first reads one entry from the top-level directory. If that entry is present, it reads one entry from the second-level page table that the directory entry points to.

Memory is reached through a simple read port. A read request is held until memory accepts it. The response comes back on a separate valid strobe after any number of cycles. The walker handles one translation at a time and ignores new requests while a walk is in flight.

Each walk ends with a one-cycle completion pulse. The pulse carries either the physical address and the combined write and user permissions, or a fault code that names the level whose entry was not present.

Top module: `ptw_top`

## Requirements
- R1: During and after a synchronous reset, `req_ready` is 1 and `mem_rd_valid` and `done_valid` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. While a walk is in flight, `req_ready` is 0, and any `req_valid`, `req_va` or `tbl_base` activity has no effect on that walk's reads or result.
- R3: The first read address is `{tbl_base[31:12], req_va[31:22], 2'b00}`. The low 12 bits of `tbl_base` are ignored.
- R4: The second read address is `{dir_entry[31:12], req_va[21:12], 2'b00}`, where `dir_entry` is the data returned by the first read.
- R5: Every 32-bit entry decodes the same way: bit 0 is present, bit 1 allows writes, bit 2 allows user access, and bits 31:12 hold the frame. Bits 11:3 have no effect on any output.
- R6: A directory entry with bit 0 clear ends the walk with `done_fault` = 1 after exactly one read.
- R7: A page-table entry with bit 0 clear ends the walk with `done_fault` = 2 after exactly two reads.
- R8: A walk with both entries present ends with `done_fault` = 0 and `done_pa = {table_entry[31:12], req_va[11:0]}`.
- R9: On success, `done_wr` is the AND of bit 1 of both entries, and `done_user` is the AND of bit 2 of both entries.
- R10: When `done_valid` is 1 with a nonzero `done_fault`, `done_pa`, `done_wr` and `done_user` are all 0.
- R11: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the request stays asserted with an unchanged address. Any response latency gives the same result.
- R12: `done_valid` is 1 for exactly one cycle per walk, and `req_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Directory base; bits 31:12 are used |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Translated physical address |
| done_wr | output | 1 | Write permitted at both levels |
| done_user | output | 1 | User access permitted at both levels |
| done_fault | output | 2 | 0 none, 1 directory not present, 2 table not present |

## Verification
The bound checker checks the following on every cycle:
- The read port stays quiet while idle.
- A stalled read request holds its value.
- Both entry addresses are formed from the captured request and the returned directory entry.
- The number of reads matches each fault code.
- Faults return zeroed data.
- Completion is a single pulse that is followed by idle.

Only the bench's scenarios can show the rest: that the frame and the combined permissions come from the right entries, that a request arriving mid-walk leaves the result untouched, and that the present bit of each level picks the right outcome. The bench shows these by sweeping every directory index and, for one directory, every table index, with stall and latency patterns varied.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned ENT_LG  = OFF_W - IDX_W;
    localparam int unsigned SPARE_W = OFF_W - 3;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPARE_W-1:0] spare;
        logic               user;
        logic               wr;
        logic               present;
    } ent_t;

    typedef struct packed {
        logic [IDX_W-1:0] dir;
        logic [IDX_W-1:0] tbl;
        logic [OFF_W-1:0] off;
    } va_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_TBL  = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WT,
        S_TBL_RD,
        S_TBL_WT,
        S_DONE
    } st_e;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } lvl_e;

    function automatic logic [VA_W-1:0] ent_addr(input logic [FRAME_W-1:0] fr,
                                                 input logic [IDX_W-1:0]   idx);
        return {fr, idx, {ENT_LG{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] pa_join(input logic [FRAME_W-1:0] fr,
                                                input logic [OFF_W-1:0]   off);
        return {fr, off};
    endfunction
endpackage

// File: rtl/ptw_ent_dec.sv
module ptw_ent_dec
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]    raw,
    input  logic               up_wr,
    input  logic               up_user,
    output logic               present,
    output logic [FRAME_W-1:0] frame,
    output logic               acc_wr,
    output logic               acc_user
);
    ent_t ent;

    always_comb begin
        ent      = ent_t'(raw);
        present  = ent.present;
        frame    = ent.frame;
        acc_wr   = ent.wr & up_wr;
        acc_user = ent.user & up_user;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  lvl_e               lvl,
    input  logic [FRAME_W-1:0] root_fr,
    input  logic [FRAME_W-1:0] dir_fr,
    input  va_t                va,
    output logic [VA_W-1:0]    addr
);
    always_comb begin
        if (lvl == LVL_TBL)
            addr = ent_addr(dir_fr, va.tbl);
        else
            addr = ent_addr(root_fr, va.dir);
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic rd_ready,
    input  logic rsp_valid,
    input  logic ent_present,
    output logic req_ready,
    output logic rd_valid,
    output logic done,
    output lvl_e lvl,
    output logic ld_req,
    output logic ld_dir,
    output logic ld_fin,
    output flt_e flt
);
    st_e state, state_nx;
    flt_e flt_nx;

    always_comb begin
        state_nx = state;
        flt_nx   = flt;
        unique case (state)
            S_IDLE: if (req_valid) begin
                state_nx = S_DIR_RD;
                flt_nx   = FLT_NONE;
            end
            S_DIR_RD: if (rd_ready) state_nx = S_DIR_WT;
            S_DIR_WT: if (rsp_valid) begin
                if (ent_present) begin
                    state_nx = S_TBL_RD;
                end else begin
                    state_nx = S_DONE;
                    flt_nx   = FLT_DIR;
                end
            end
            S_TBL_RD: if (rd_ready) state_nx = S_TBL_WT;
            S_TBL_WT: if (rsp_valid) begin
                state_nx = S_DONE;
                if (!ent_present) flt_nx = FLT_TBL;
            end
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            flt   <= FLT_NONE;
        end else begin
            state <= state_nx;
            flt   <= flt_nx;
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        rd_valid  = (state == S_DIR_RD) || (state == S_TBL_RD);
        done      = (state == S_DONE);
        lvl       = ((state == S_TBL_RD) || (state == S_TBL_WT)) ? LVL_TBL : LVL_DIR;
        ld_req    = (state == S_IDLE) && req_valid;
        ld_dir    = (state == S_DIR_WT) && rsp_valid && ent_present;
        ld_fin    = (state == S_TBL_WT) && rsp_valid && ent_present;
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    input  logic [31:0] tbl_base,
    output logic        mem_rd_valid,
    input  logic        mem_rd_ready,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done_valid,
    output logic [31:0] done_pa,
    output logic        done_wr,
    output logic        done_user,
    output logic [1:0]  done_fault
);
    va_t                va_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] dir_fr_q;
    logic               dir_wr_q;
    logic               dir_user_q;
    logic [VA_W-1:0]    pa_q;
    logic               wr_q;
    logic               user_q;

    lvl_e               lvl;
    logic               ld_req;
    logic               ld_dir;
    logic               ld_fin;
    flt_e               flt;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic               ent_wr;
    logic               ent_user;
    logic               up_wr;
    logic               up_user;

    assign up_wr   = (lvl == LVL_TBL) ? dir_wr_q   : 1'b1;
    assign up_user = (lvl == LVL_TBL) ? dir_user_q : 1'b1;

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .rd_ready    (mem_rd_ready),
        .rsp_valid   (mem_rsp_valid),
        .ent_present (ent_present),
        .req_ready   (req_ready),
        .rd_valid    (mem_rd_valid),
        .done        (done_valid),
        .lvl         (lvl),
        .ld_req      (ld_req),
        .ld_dir      (ld_dir),
        .ld_fin      (ld_fin),
        .flt         (flt)
    );

    ptw_ent_dec u_dec (
        .raw      (mem_rsp_data),
        .up_wr    (up_wr),
        .up_user  (up_user),
        .present  (ent_present),
        .frame    (ent_frame),
        .acc_wr   (ent_wr),
        .acc_user (ent_user)
    );

    ptw_addr_gen u_agen (
        .lvl     (lvl),
        .root_fr (root_q),
        .dir_fr  (dir_fr_q),
        .va      (va_q),
        .addr    (mem_rd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q       <= '0;
            root_q     <= '0;
            dir_fr_q   <= '0;
            dir_wr_q   <= 1'b0;
            dir_user_q <= 1'b0;
            pa_q       <= '0;
            wr_q       <= 1'b0;
            user_q     <= 1'b0;
        end else begin
            if (ld_req) begin
                va_q   <= va_t'(req_va);
                root_q <= tbl_base[VA_W-1:OFF_W];
                pa_q   <= '0;
                wr_q   <= 1'b0;
                user_q <= 1'b0;
            end
            if (ld_dir) begin
                dir_fr_q   <= ent_frame;
                dir_wr_q   <= ent_wr;
                dir_user_q <= ent_user;
            end
            if (ld_fin) begin
                pa_q   <= pa_join(ent_frame, va_q.off);
                wr_q   <= ent_wr;
                user_q <= ent_user;
            end
        end
    end

    assign done_pa    = pa_q;
    assign done_wr    = wr_q;
    assign done_user  = user_q;
    assign done_fault = flt;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic [31:0] tbl_base,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic [31:0] mem_rsp_data,
    input logic        done_valid,
    input logic [31:0] done_pa,
    input logic        done_wr,
    input logic        done_user,
    input logic [1:0]  done_fault
);
    logic [1:0]  rd_cnt;
    logic [31:0] va_c;
    logic [31:0] base_c;
    logic [31:0] dir_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt <= 2'd0;
            va_c   <= '0;
            base_c <= '0;
            dir_c  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                rd_cnt <= 2'd0;
                va_c   <= req_va;
                base_c <= tbl_base;
            end else if (mem_rd_valid && mem_rd_ready) begin
                rd_cnt <= rd_cnt + 2'd1;
            end
            if (mem_rsp_valid && rd_cnt == 2'd1) dir_c <= mem_rsp_data;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_rd_valid && !done_valid));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_dir_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && rd_cnt == 2'd0) |->
            (mem_rd_addr == {base_c[31:12], va_c[31:22], 2'b00}));

    p_tbl_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && rd_cnt == 2'd1) |->
            (mem_rd_addr == {dir_c[31:12], va_c[21:12], 2'b00}));

    p_dir_fault_reads_r6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault == 2'd1) |-> (rd_cnt == 2'd1));

    p_tbl_fault_reads_r7: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault == 2'd2) |-> (rd_cnt == 2'd2));

    p_ok_offset_r8: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault == 2'd0) |->
            (rd_cnt == 2'd2 && done_pa[11:0] == va_c[11:0]));

    p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != 2'd0) |->
            (done_pa == 32'd0 && !done_wr && !done_user));

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));
endmodule

bind ptw_top ptw_chk u_chk (.*);

// File: tb/sim_ptw_top.sv
`timescale 1ns/1ps
module sim_ptw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_pa;
    logic        done_wr;
    logic        done_user;
    logic [1:0]  done_fault;

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ptw_top u0 (.*);

    localparam logic [31:0] TBL_AREA = 32'h0200_0000;

    function automatic logic [31:0] pde_of(input logic [9:0] d);
        logic [19:0] fr;
        fr = 20'h02000 + {10'd0, d};
        return {fr, 9'h1A5, d[1], d[0] ^ d[3], ((d % 10'd3) != 10'd0)};
    endfunction

    function automatic logic [31:0] pte_of(input logic [9:0] d, input logic [9:0] t);
        return {({d, t} ^ 20'h5A5A5), 9'h0F3, t[1] | t[2], t[0], ((t % 10'd5) != 10'd0)};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] b);
        if (a[31:12] == b[31:12]) return pde_of(a[11:2]);
        if (a >= TBL_AREA && a < TBL_AREA + 32'h0040_0000) return pte_of(a[21:12], a[11:2]);
        return 32'hDEAD_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input int stall, input int lat, input bit spam);
        logic [31:0] pde, pte, a, exp_pa;
        logic [1:0]  exp_flt;
        logic        exp_w, exp_u;
        int          exp_reads, nreads;
        bit          got;
        pde = pde_of(va[31:22]);
        pte = pte_of(va[31:22], va[21:12]);
        if (!pde[0]) begin
            exp_flt = 2'd1; exp_reads = 1; exp_pa = '0; exp_w = 0; exp_u = 0;
        end else if (!pte[0]) begin
            exp_flt = 2'd2; exp_reads = 2; exp_pa = '0; exp_w = 0; exp_u = 0;
        end else begin
            exp_flt = 2'd0; exp_reads = 2; exp_pa = {pte[31:12], va[11:0]};
            exp_w = pde[1] & pte[1]; exp_u = pde[2] & pte[2];
        end
        req_va = va; tbl_base = base; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2 ready when idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        if (spam) begin
            req_va = ~va; tbl_base = 32'h0000_0000;
        end else begin
            req_valid = 1'b0;
        end
        nreads = 0; got = 0;
        for (int g = 0; g < 400; g++) begin
            if (done_valid) begin got = 1; break; end
            if (mem_rd_valid) begin
                a = mem_rd_addr;
                if (nreads == 0)
                    chk(a == {base[31:12], va[31:22], 2'b00}, "R3 dir addr", a,
                        {base[31:12], va[31:22], 2'b00});
                else
                    chk(a == {pde[31:12], va[21:12], 2'b00}, "R4 tbl addr", a,
                        {pde[31:12], va[21:12], 2'b00});
                nreads++;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    chk(mem_rd_valid && mem_rd_addr == a, "R11 hold", mem_rd_addr, a);
                end
                mem_rd_ready = 1'b1;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                if (spam) chk(req_ready == 1'b0, "R2 busy", {31'd0, req_ready}, 32'd0);
                for (int l = 0; l < lat; l++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(a, base);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'hFFFF_FFFF;
            end else begin
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(got, "R12 completion seen", {31'd0, got}, 32'd1);
        chk(nreads == exp_reads, (exp_flt == 2'd1) ? "R6 read count" : "R7 read count",
            nreads, exp_reads);
        chk(done_fault == exp_flt, (exp_flt == 2'd1) ? "R6 dir fault" :
            (exp_flt == 2'd2) ? "R7 tbl fault" : "R5 present decode",
            {30'd0, done_fault}, {30'd0, exp_flt});
        chk(done_pa == exp_pa, (exp_flt == 2'd0) ? "R8 phys addr" : "R10 zero pa",
            done_pa, exp_pa);
        chk(done_wr == exp_w && done_user == exp_u,
            (exp_flt == 2'd0) ? "R9 perms" : "R10 zero perms",
            {30'd0, done_user, done_wr}, {30'd0, exp_u, exp_w});
        @(negedge clk);
        chk(!done_valid && req_ready, "R12 pulse then idle",
            {30'd0, done_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0]  d, t;
        logic [11:0] off;
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_rd_valid && !done_valid, "R1 in reset",
            {29'd0, req_ready, mem_rd_valid, done_valid}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_rd_valid && !done_valid, "R1 after reset",
            {29'd0, req_ready, mem_rd_valid, done_valid}, 32'd4);
        // every directory index, junk low base bits (R3), varied stall and latency (R11)
        for (int i = 0; i < 1024; i++) begin
            d = 10'(i);
            t = 10'((i * 37 + 5) % 1024);
            off = 12'((i * 97 + 13) % 4096);
            walk({d, t, off}, 32'h0003_F123, i % 3, i % 4, d[4]);
        end
        // every table index under one present directory entry
        for (int i = 0; i < 1024; i++) begin
            t = 10'(i);
            off = 12'((i * 13 + 7) % 4096);
            walk({10'd5, t, off}, 32'h0010_0000, 0, i % 2, i[3]);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule